// File: doc/BRIEF.md
# Diagnostic Reset and Self-Test Sequencer

This block produces the reset, self-test and inhibit controls for the diagnostic circuits of a multiplexer/demultiplexer pair. It combines three reset sources. The first is a display-reset pushbutton, which is honoured only while self-test is off. The second is a long hold that starts when the self-test switch is turned off. The third is the loss of frame synchronisation at the demultiplexer.

The pushbutton and self-test switch arrive as debounced levels that are already synchronous to `clk`. The frame-sync status is asynchronous and passes through a two-flop synchroniser. Both timed holds are counter one-shots. They advance on a one-cycle reference strobe, `tick_i`, which is nominally 1 kHz. Their lengths are parameters counted in ticks: `LONG_TICKS` (default 10000, about 10 s) and `SHORT_TICKS` (default 500, about 0.5 s). All outputs are active high.

Top module: `diag_reset_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every output is low. This assumes `fsync_i` is high and both switch inputs are low.
- R2: When self-test is off and no hold is running, `mux_diag_rst_o` and `temp_alarm_rst_o` go high one cycle after `btn_reset_i` goes high. They go low one cycle after it goes low.
- R3: While the self-test latch is set, `btn_reset_i` has no effect on any reset output, except through a hold that is already running.
- R4: `selftest_a_o` and `selftest_b_o` are both high from one cycle after `selftest_sw_i` goes high until one cycle after it goes low.
- R5: Turning the switch off starts the long hold in the same edge that clears the latch. For LONG_TICKS ticks, all three reset outputs and `diag_inhibit_o` stay high.
- R6: `demux_diag_rst_o` is high from two cycles after `fsync_i` goes low, and it stays high while `fsync_i` remains low.
- R7: A falling edge of the synchronised frame sync loads the short hold one cycle after the reset in R6. The short hold keeps `diag_inhibit_o` high for SHORT_TICKS ticks. Each hold counts down only on cycles where `tick_i` is high, so a hold can end only on such a cycle.
- R8: A retrigger while a hold is running reloads that hold to its full length.
- R9: `demux_diag_rst_o` is the OR of the gated pushbutton reset, the synchronised frame-sync-low condition and the long hold.
- R10: `diag_inhibit_o` is the OR of the long hold and the short hold.
- R11: When a trigger and a tick fall in the same cycle, the trigger wins. The hold then lasts exactly LONG_TICKS (or SHORT_TICKS) further ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle reference strobe that advances the holds |
| btn_reset_i | input | 1 | Debounced display-reset pushbutton, 1 = pressed |
| selftest_sw_i | input | 1 | Self-test switch level, 1 = on |
| fsync_i | input | 1 | Asynchronous frame-sync status, 1 = in sync |
| mux_diag_rst_o | output | 1 | Multiplexer diagnostic reset |
| demux_diag_rst_o | output | 1 | Demultiplexer diagnostic reset |
| temp_alarm_rst_o | output | 1 | Temperature-alarm reset |
| selftest_a_o | output | 1 | Self-test mode output, first group |
| selftest_b_o | output | 1 | Self-test mode output, second group |
| diag_inhibit_o | output | 1 | Diagnostics inhibit |

## Verification
Two situations are hard to reach from the ports. One is a trigger that lands in exactly the cycle of a reference tick. The other is a retrigger of a hold that is already running, because random toggling rarely produces either one. The stimulus steps the bench tick divider until a tick is about to be driven, then releases the switch in that same cycle and counts the high cycles of the inhibit against the exact figure. For the retrigger, frame sync is dropped, briefly restored for longer than the synchroniser latency, and dropped again half way through the short hold. A long random phase then toggles all three levels against a cycle-level reference model.

// File: rtl/drs_pkg.sv
package drs_pkg;

  // Bundle of the six control outputs driven by the sequencer
  typedef struct packed {
    logic mux_rst;
    logic demux_rst;
    logic temp_rst;
    logic st_a;
    logic st_b;
    logic inhibit;
  } drs_ctl_t;

  // Nominal reference tick rate the hold lengths are expressed in
  localparam int unsigned TICK_HZ = 1000;

  // Counter width able to hold the value n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/drs_sync.sv
module drs_sync #(
  parameter int unsigned STAGES    = 2,
  parameter bit          RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RESET_VAL;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RESET_VAL;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/drs_oneshot.sv
module drs_oneshot #(
  parameter int unsigned LEN = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic trig_i,
  output logic active_o
);
  import drs_pkg::*;

  localparam int unsigned W = cnt_width(LEN);
  localparam logic [W-1:0] FULL = W'(LEN);

  logic [W-1:0] remain_q;

  // A trigger always reloads the full length, even mid-count or on a tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (trig_i) begin
      remain_q <= FULL;
    end else if (tick_i && (remain_q != '0)) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign active_o = (remain_q != '0);
endmodule

// File: rtl/drs_latches.sv
module drs_latches (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_i,
  input  logic sw_i,
  input  logic fs_sync_i,
  output logic err_q_o,
  output logic st_q_o,
  output logic st_off_o,
  output logic fs_fall_o
);
  logic err_q, st_q, fs_d_q;

  // Error-reset latch: set while the button is pressed, cleared on release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          err_q <= 1'b0;
    else if (!btn_i)     err_q <= 1'b0;
    else if (!err_q)     err_q <= 1'b1;
  end

  // Self-test latch follows the switch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          st_q <= 1'b0;
    else if (sw_i)       st_q <= 1'b1;
    else                 st_q <= 1'b0;
  end

  // Delay stage for the synchronised frame sync
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fs_d_q <= 1'b1;
    else        fs_d_q <= fs_sync_i;
  end

  assign err_q_o   = err_q;
  assign st_q_o    = st_q;
  assign st_off_o  = st_q & ~sw_i;
  assign fs_fall_o = fs_d_q & ~fs_sync_i;
endmodule

// File: rtl/diag_reset_seq.sv
module diag_reset_seq #(
  parameter int unsigned LONG_TICKS  = 10000,
  parameter int unsigned SHORT_TICKS = 500,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic btn_reset_i,
  input  logic selftest_sw_i,
  input  logic fsync_i,
  output logic mux_diag_rst_o,
  output logic demux_diag_rst_o,
  output logic temp_alarm_rst_o,
  output logic selftest_a_o,
  output logic selftest_b_o,
  output logic diag_inhibit_o
);
  import drs_pkg::*;

  localparam int unsigned HOLDS = 2;
  localparam int unsigned H_LONG = 0;
  localparam int unsigned H_SHORT = 1;

  logic fs_sync;
  logic err_q, st_q, st_off, fs_fall;
  logic [HOLDS-1:0] hold_trig, hold_act;
  logic gated_btn, sync_lost;
  drs_ctl_t ctl;

  drs_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_fs_sync (
    .clk(clk), .rst_n(rst_n), .d_i(fsync_i), .q_o(fs_sync)
  );

  drs_latches u_lat (
    .clk(clk), .rst_n(rst_n),
    .btn_i(btn_reset_i), .sw_i(selftest_sw_i), .fs_sync_i(fs_sync),
    .err_q_o(err_q), .st_q_o(st_q), .st_off_o(st_off), .fs_fall_o(fs_fall)
  );

  assign hold_trig[H_LONG]  = st_off;
  assign hold_trig[H_SHORT] = fs_fall;

  generate
    for (genvar h = 0; h < HOLDS; h++) begin : g_hold
      localparam int unsigned LEN_H = (h == H_LONG) ? LONG_TICKS : SHORT_TICKS;
      drs_oneshot #(.LEN(LEN_H)) u_os (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .trig_i(hold_trig[h]), .active_o(hold_act[h])
      );
    end
  endgenerate

  assign gated_btn = err_q & ~st_q;
  assign sync_lost = ~fs_sync;

  always_comb begin
    ctl.mux_rst   = gated_btn | hold_act[H_LONG];
    ctl.temp_rst  = gated_btn | hold_act[H_LONG];
    ctl.demux_rst = gated_btn | sync_lost | hold_act[H_LONG];
    ctl.st_a      = st_q;
    ctl.st_b      = st_q;
    ctl.inhibit   = |hold_act;
  end

  assign mux_diag_rst_o   = ctl.mux_rst;
  assign demux_diag_rst_o = ctl.demux_rst;
  assign temp_alarm_rst_o = ctl.temp_rst;
  assign selftest_a_o     = ctl.st_a;
  assign selftest_b_o     = ctl.st_b;
  assign diag_inhibit_o   = ctl.inhibit;
endmodule

// File: rtl/drs_checker.sv
module drs_checker (
  input logic clk,
  input logic rst_n,
  input logic tick_i,
  input logic btn_reset_i,
  input logic fsync_i,
  input logic mux_diag_rst_o,
  input logic demux_diag_rst_o,
  input logic temp_alarm_rst_o,
  input logic selftest_a_o,
  input logic diag_inhibit_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  assert_btn_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_diag_rst_o && !diag_inhibit_o) |-> $past(btn_reset_i));

  assert_btn_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (selftest_a_o && !diag_inhibit_o) |-> (!mux_diag_rst_o && !temp_alarm_rst_o));

  assert_long_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(selftest_a_o) |-> (mux_diag_rst_o && temp_alarm_rst_o && diag_inhibit_o));

  assert_sync_loss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && !$past(fsync_i) && !$past(fsync_i, 2)) |-> demux_diag_rst_o);

  assert_end_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(diag_inhibit_o) |-> $past(tick_i));
endmodule

bind diag_reset_seq drs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .btn_reset_i(btn_reset_i),
  .fsync_i(fsync_i), .mux_diag_rst_o(mux_diag_rst_o),
  .demux_diag_rst_o(demux_diag_rst_o), .temp_alarm_rst_o(temp_alarm_rst_o),
  .selftest_a_o(selftest_a_o), .diag_inhibit_o(diag_inhibit_o)
);

// File: tb/sim_diag_reset_seq.sv
`timescale 1ns/1ps
module sim_diag_reset_seq;
  localparam int LONG  = 40;
  localparam int SHORT = 6;
  localparam int DIV   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, btn = 1'b0, sw = 1'b0, fsync = 1'b1;
  logic mux_o, demux_o, temp_o, sta_o, stb_o, inh_o;
  int tests = 0, fails = 0, tick_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  diag_reset_seq #(.LONG_TICKS(LONG), .SHORT_TICKS(SHORT)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .btn_reset_i(btn),
    .selftest_sw_i(sw), .fsync_i(fsync),
    .mux_diag_rst_o(mux_o), .demux_diag_rst_o(demux_o), .temp_alarm_rst_o(temp_o),
    .selftest_a_o(sta_o), .selftest_b_o(stb_o), .diag_inhibit_o(inh_o)
  );

  // Reference model built from the requirements
  logic m_err, m_st, m_s1, m_s2, m_s3;
  int m_long, m_short;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_err <= 0; m_st <= 0; m_s1 <= 1; m_s2 <= 1; m_s3 <= 1; m_long <= 0; m_short <= 0;
    end else begin
      m_err <= btn; m_st <= sw; m_s1 <= fsync; m_s2 <= m_s1; m_s3 <= m_s2;
      if (m_st && !sw) m_long <= LONG;
      else if (tick && m_long > 0) m_long <= m_long - 1;
      if (m_s3 && !m_s2) m_short <= SHORT;
      else if (tick && m_short > 0) m_short <= m_short - 1;
    end
  end

  function automatic bit exp_mux();
    return (m_err && !m_st) || (m_long > 0);
  endfunction
  function automatic bit exp_demux();
    return exp_mux() || !m_s2;
  endfunction
  function automatic bit exp_inh();
    return (m_long > 0) || (m_short > 0);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 mux", mux_o, exp_mux());
    chk("R2 temp", temp_o, exp_mux());
    chk("R9 demux", demux_o, exp_demux());
    chk("R4 st_a", sta_o, m_st);
    chk("R4 st_b", stb_o, m_st);
    chk("R10 inhibit", inh_o, exp_inh());
  endtask

  task automatic step();
    @(negedge clk);
    if (rst_n) check_all();
    tick_cnt = (tick_cnt + 1) % DIV;
    tick = (tick_cnt == 0);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1 reset state
    steps(3);
    chk("R1 mux", mux_o, 0); chk("R1 demux", demux_o, 0); chk("R1 temp", temp_o, 0);
    chk("R1 st", sta_o | stb_o, 0); chk("R1 inh", inh_o, 0);
    rst_n = 1'b1;
    step();
    chk("R1 after release", mux_o | demux_o | temp_o | sta_o | inh_o, 0);

    // R2 press and release
    btn = 1; step();
    chk("R2 press", mux_o & temp_o & demux_o, 1);
    steps(5); btn = 0; step();
    chk("R2 release", mux_o | temp_o, 0);

    // R3 press during self-test
    sw = 1; steps(3);
    chk("R4 on", sta_o & stb_o, 1);
    btn = 1; steps(4);
    chk("R3 ignored", mux_o | temp_o | demux_o, 0);
    btn = 0; steps(2);

    // R5 switch off starts long hold
    sw = 0; step();
    chk("R5 start", mux_o & temp_o & demux_o & inh_o, 1);
    steps((LONG - 1) * DIV - 1);
    chk("R5 still held", mux_o & inh_o, 1);
    steps(2 * DIV + 1);
    chk("R5 released", mux_o | inh_o, 0);

    // R6/R7 frame sync loss
    fsync = 0; step();
    chk("R6 not yet", demux_o, 0);
    step();
    chk("R6 demux", demux_o, 1);
    chk("R7 not yet", inh_o, 0);
    step();
    chk("R7 inhibit", inh_o, 1);
    // R8 retrigger mid-hold
    steps((SHORT / 2) * DIV);
    fsync = 1; steps(4);
    fsync = 0; steps(3);
    steps((SHORT - 1) * DIV);
    chk("R8 reloaded", inh_o, 1);
    steps(2 * DIV + 2);
    chk("R8 done", inh_o, 0);
    chk("R6 held", demux_o, 1);
    fsync = 1; steps(3);

    // R11 trigger on a tick cycle
    sw = 1; steps(3);
    do step(); while (!tick);
    sw = 0;
    begin
      int n = 0;
      step();
      while (inh_o && n < 10 * LONG * DIV) begin n++; step(); end
      chk("R11 length", (n == LONG * DIV), 1);
    end

    // random phase
    for (int i = 0; i < 20000; i++) begin
      step();
      if ($urandom_range(63) == 0)  btn = ~btn;
      if ($urandom_range(299) == 0) sw = ~sw;
      if ($urandom_range(199) == 0) fsync = ~fsync;
    end
    steps(2);
    finish_run();
  end
endmodule